// File: doc/BRIEF.md
# Device-Side Translation Buffer with Round-Robin Victim Slot

This block is a small, fully associative translation cache for a device-side memory management unit. Each slot keeps a virtual page base, a two-bit page-size code and a valid flag, alongside a physical page base and an attribute field. Software owns replacement. A victim pointer names the slot that read-back and entry loads act on. Software moves the pointer directly, and every successful load advances it round-robin.

Commands arrive on one command port. One command sets the victim pointer. The others invalidate the victim slot, commit the staged entry into the victim slot, invalidate every entry that covers an address, or invalidate everything and rewind the pointer. Entry contents are staged through a separate write strobe before the commit. A lookup port translates a device address. It answers one cycle later with a hit or a one-cycle miss strobe.

Four page sizes are supported, so coverage and translation keep a size-dependent number of low address bits. When several slots cover the same address, the lowest-numbered one is used.

Top module: `devmmu_tlb`

## Requirements
- R1: After reset every slot is invalid, the victim pointer is 0, and lk_hit, lk_miss, lk_pa and lk_attr are 0.
- R2: Page-size code 0 is 16 MB, 1 is 1 MB, 2 is 64 KB and 3 is 4 KB. A valid slot covers an address when all address bits above the page size equal the slot's virtual base. On a commit, the virtual base bits below the page size are stored as zero.
- R3: Command codes on cmd_op are 1 set victim, 2 flush victim slot, 3 commit, 4 flush by address (cmd_arg), and 5 flush all. Codes 0, 6 and 7 do nothing. A commit writes the staged entry into the victim slot and marks it valid only when the command immediately before it was a flush of the victim slot. Otherwise the commit changes neither the slots nor the victim pointer.
- R4: After an effective commit, the victim pointer advances by one and wraps from NUM_ENTRIES-1 to 0.
- R5: Set victim loads cmd_arg into the pointer. A value of NUM_ENTRIES or more is ignored. The rd_* outputs always show the slot named by the pointer.
- R6: Flushing the victim slot clears that slot's valid flag and leaves the pointer unchanged.
- R7: Flush by address clears every valid slot that covers cmd_arg. It leaves other slots and the victim pointer unchanged.
- R8: Flush all clears every slot and sets the victim pointer to 0.
- R9: A lookup sampled with lk_valid high produces its result in the next cycle. On a hit, lk_hit is high, lk_pa combines the slot's physical base above the page size with the address bits below it, and lk_attr is the slot's attribute.
- R10: When several valid slots cover the lookup address, the lowest-numbered slot supplies the translation.
- R11: A lookup that no valid slot covers raises lk_miss for exactly one cycle, with lk_pa and lk_attr at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R3) |
| cmd_arg | input | 32 | Victim value or flush address |
| stage_wr | input | 1 | Write staging registers |
| stage_va | input | 32 | Staged virtual base |
| stage_size | input | 2 | Staged page-size code |
| stage_pa | input | 32 | Staged physical base |
| stage_attr | input | ATTR_W | Staged attributes |
| victim | output | clog2(NUM_ENTRIES) | Current victim pointer |
| rd_valid | output | 1 | Valid flag of victim slot |
| rd_va | output | 32 | Virtual base of victim slot |
| rd_size | output | 2 | Page-size code of victim slot |
| rd_pa | output | 32 | Physical base of victim slot |
| rd_attr | output | ATTR_W | Attributes of victim slot |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Device address to translate |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_miss | output | 1 | Lookup miss strobe |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | ATTR_W | Attributes of the hitting slot |

## Verification
Lookups are tried at the last and first byte of each page size, and one address past each page. This separates the four offset widths and exposes off-by-one boundaries. Two overlapping slots of different sizes show whether priority goes by slot number or by size. Commits are issued with and without the preceding slot flush, and with an unrelated command in between, to prove the ordering rule. Flush-by-address, single-slot flush and global flush are each followed by read-back of every affected and unaffected slot, which separates the scope of the three invalidations.

// File: rtl/devmmu_tlb_pkg.sv
`timescale 1ns/1ps
package devmmu_tlb_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_SET_VICTIM = 3'd1,
    OP_FLUSH_SLOT = 3'd2,
    OP_LOAD       = 3'd3,
    OP_FLUSH_ADDR = 3'd4,
    OP_FLUSH_ALL  = 3'd5
  } tlb_op_e;

  // Low-bit mask of the in-page offset for a size code.
  function automatic addr_t offset_mask(input logic [1:0] code);
    case (code)
      2'd0:    offset_mask = 32'h00FF_FFFF;
      2'd1:    offset_mask = 32'h000F_FFFF;
      2'd2:    offset_mask = 32'h0000_FFFF;
      default: offset_mask = 32'h0000_0FFF;
    endcase
  endfunction

  function automatic addr_t page_base(input addr_t a, input logic [1:0] code);
    page_base = a & ~offset_mask(code);
  endfunction

  function automatic logic covers(input addr_t base, input logic [1:0] code, input addr_t da);
    covers = ((base ^ da) & ~offset_mask(code)) == '0;
  endfunction

  function automatic addr_t xlate(input addr_t pa, input logic [1:0] code, input addr_t da);
    xlate = (pa & ~offset_mask(code)) | (da & offset_mask(code));
  endfunction
endpackage

// File: rtl/devmmu_tlb_ctrl.sv
`timescale 1ns/1ps
module devmmu_tlb_ctrl
  import devmmu_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  addr_t            cmd_arg,
  output logic [IDX_W-1:0] victim,
  output logic             armed,
  output logic             ev_set_victim,
  output logic             ev_flush_slot,
  output logic             ev_load,
  output logic             ev_flush_addr,
  output logic             ev_flush_all
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  function automatic logic [IDX_W-1:0] next_victim(input logic [IDX_W-1:0] v);
    next_victim = (v == LAST_IDX) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    ev_set_victim = cmd_valid && (cmd_op == OP_SET_VICTIM) && (cmd_arg < ADDR_W'(NUM_ENTRIES));
    ev_flush_slot = cmd_valid && (cmd_op == OP_FLUSH_SLOT);
    ev_load       = cmd_valid && (cmd_op == OP_LOAD) && armed;
    ev_flush_addr = cmd_valid && (cmd_op == OP_FLUSH_ADDR);
    ev_flush_all  = cmd_valid && (cmd_op == OP_FLUSH_ALL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim <= '0;
      armed  <= 1'b0;
    end else begin
      if (cmd_valid) armed <= (cmd_op == OP_FLUSH_SLOT);
      if (ev_flush_all)       victim <= '0;
      else if (ev_set_victim) victim <= cmd_arg[IDX_W-1:0];
      else if (ev_load)       victim <= next_victim(victim);
    end
  end
endmodule

// File: rtl/devmmu_tlb_entries.sv
`timescale 1ns/1ps
module devmmu_tlb_entries
  import devmmu_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int ATTR_W = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  addr_t                  wr_va,
  input  logic [1:0]             wr_size,
  input  addr_t                  wr_pa,
  input  logic [ATTR_W-1:0]      wr_attr,
  input  logic                   kill_slot_en,
  input  logic [IDX_W-1:0]       kill_idx,
  input  logic                   kill_addr_en,
  input  addr_t                  kill_addr,
  input  logic                   kill_all,
  input  logic [IDX_W-1:0]       rd_idx,
  input  addr_t                  lk_addr,
  input  logic [IDX_W-1:0]       sel_idx,
  output logic [NUM_ENTRIES-1:0] valid_vec,
  output logic [NUM_ENTRIES-1:0] lk_match_vec,
  output logic                   rd_valid,
  output addr_t                  rd_va,
  output logic [1:0]             rd_size,
  output addr_t                  rd_pa,
  output logic [ATTR_W-1:0]      rd_attr,
  output addr_t                  sel_pa,
  output logic [1:0]             sel_size,
  output logic [ATTR_W-1:0]      sel_attr
);
  addr_t             va_a   [NUM_ENTRIES];
  addr_t             pa_a   [NUM_ENTRIES];
  logic [1:0]        size_a [NUM_ENTRIES];
  logic [ATTR_W-1:0] attr_a [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    addr_t             va_r, pa_r;
    logic [1:0]        size_r;
    logic [ATTR_W-1:0] attr_r;
    logic              valid_r;
    logic              hit_wr, hit_kill;

    assign hit_wr   = wr_en && (wr_idx == IDX_W'(i));
    assign hit_kill = (kill_slot_en && (kill_idx == IDX_W'(i))) ||
                      (kill_addr_en && covers(va_r, size_r, kill_addr));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        va_r    <= '0;
        pa_r    <= '0;
        size_r  <= '0;
        attr_r  <= '0;
        valid_r <= 1'b0;
      end else if (kill_all) begin
        valid_r <= 1'b0;
      end else if (hit_wr) begin
        va_r    <= page_base(wr_va, wr_size);
        pa_r    <= wr_pa;
        size_r  <= wr_size;
        attr_r  <= wr_attr;
        valid_r <= 1'b1;
      end else if (hit_kill) begin
        valid_r <= 1'b0;
      end
    end

    assign va_a[i]         = va_r;
    assign pa_a[i]         = pa_r;
    assign size_a[i]       = size_r;
    assign attr_a[i]       = attr_r;
    assign valid_vec[i]    = valid_r;
    assign lk_match_vec[i] = valid_r && covers(va_r, size_r, lk_addr);
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_va    = '0;
    rd_size  = '0;
    rd_pa    = '0;
    rd_attr  = '0;
    if (int'(rd_idx) < NUM_ENTRIES) begin
      rd_valid = valid_vec[rd_idx];
      rd_va    = va_a[rd_idx];
      rd_size  = size_a[rd_idx];
      rd_pa    = pa_a[rd_idx];
      rd_attr  = attr_a[rd_idx];
    end
  end

  always_comb begin
    sel_pa   = '0;
    sel_size = '0;
    sel_attr = '0;
    if (int'(sel_idx) < NUM_ENTRIES) begin
      sel_pa   = pa_a[sel_idx];
      sel_size = size_a[sel_idx];
      sel_attr = attr_a[sel_idx];
    end
  end
endmodule

// File: rtl/devmmu_tlb_pick.sv
`timescale 1ns/1ps
module devmmu_tlb_pick #(
  parameter int NUM_ENTRIES = 6,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] req,
  output logic                   any,
  output logic [IDX_W-1:0]       idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/devmmu_tlb.sv
`timescale 1ns/1ps
module devmmu_tlb
  import devmmu_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 6,
  parameter int ATTR_W = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [31:0]       cmd_arg,
  input  logic              stage_wr,
  input  logic [31:0]       stage_va,
  input  logic [1:0]        stage_size,
  input  logic [31:0]       stage_pa,
  input  logic [ATTR_W-1:0] stage_attr,
  output logic [IDX_W-1:0]  victim,
  output logic              rd_valid,
  output logic [31:0]       rd_va,
  output logic [1:0]        rd_size,
  output logic [31:0]       rd_pa,
  output logic [ATTR_W-1:0] rd_attr,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [31:0]       lk_pa,
  output logic [ATTR_W-1:0] lk_attr
);
  addr_t             stg_va, stg_pa;
  logic [1:0]        stg_size;
  logic [ATTR_W-1:0] stg_attr;

  logic armed, ev_set_victim, ev_flush_slot, ev_load, ev_flush_addr, ev_flush_all;
  logic [NUM_ENTRIES-1:0] valid_vec, lk_match_vec;
  logic                   lk_any;
  logic [IDX_W-1:0]       lk_idx;
  addr_t                  sel_pa;
  logic [1:0]             sel_size;
  logic [ATTR_W-1:0]      sel_attr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_va   <= '0;
      stg_pa   <= '0;
      stg_size <= '0;
      stg_attr <= '0;
    end else if (stage_wr) begin
      stg_va   <= stage_va;
      stg_pa   <= stage_pa;
      stg_size <= stage_size;
      stg_attr <= stage_attr;
    end
  end

  devmmu_tlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .victim(victim), .armed(armed), .ev_set_victim(ev_set_victim),
    .ev_flush_slot(ev_flush_slot), .ev_load(ev_load),
    .ev_flush_addr(ev_flush_addr), .ev_flush_all(ev_flush_all)
  );

  devmmu_tlb_entries #(.NUM_ENTRIES(NUM_ENTRIES), .ATTR_W(ATTR_W)) entries_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ev_load), .wr_idx(victim), .wr_va(stg_va), .wr_size(stg_size),
    .wr_pa(stg_pa), .wr_attr(stg_attr),
    .kill_slot_en(ev_flush_slot), .kill_idx(victim),
    .kill_addr_en(ev_flush_addr), .kill_addr(cmd_arg), .kill_all(ev_flush_all),
    .rd_idx(victim), .lk_addr(lk_addr), .sel_idx(lk_idx),
    .valid_vec(valid_vec), .lk_match_vec(lk_match_vec),
    .rd_valid(rd_valid), .rd_va(rd_va), .rd_size(rd_size), .rd_pa(rd_pa), .rd_attr(rd_attr),
    .sel_pa(sel_pa), .sel_size(sel_size), .sel_attr(sel_attr)
  );

  devmmu_tlb_pick #(.NUM_ENTRIES(NUM_ENTRIES)) pick_i (
    .req(lk_match_vec), .any(lk_any), .idx(lk_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_miss <= 1'b0;
      lk_pa   <= '0;
      lk_attr <= '0;
    end else begin
      lk_hit  <= lk_valid && lk_any;
      lk_miss <= lk_valid && !lk_any;
      lk_pa   <= (lk_valid && lk_any) ? xlate(sel_pa, sel_size, lk_addr) : '0;
      lk_attr <= (lk_valid && lk_any) ? sel_attr : '0;
    end
  end
endmodule

// File: rtl/devmmu_tlb_chk.sv
`timescale 1ns/1ps
module devmmu_tlb_chk #(
  parameter int NUM_ENTRIES = 6,
  parameter int ATTR_W = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [2:0]             cmd_op,
  input logic [IDX_W-1:0]       victim,
  input logic                   armed,
  input logic                   ev_load,
  input logic                   ev_flush_slot,
  input logic                   ev_flush_all,
  input logic [NUM_ENTRIES-1:0] valid_vec,
  input logic                   lk_valid,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic [31:0]            lk_pa,
  input logic [ATTR_W-1:0]      lk_attr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  assert_load_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> victim == (($past(victim) == LAST_IDX) ? '0 : $past(victim) + 1'b1));

  assert_load_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> valid_vec[$past(victim)]);

  assert_unarmed_load_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && !armed) |=> ($stable(valid_vec) && $stable(victim)));

  assert_victim_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(victim) < NUM_ENTRIES);

  assert_slot_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush_slot |=> (!valid_vec[$past(victim)] && victim == $past(victim)));

  assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush_all |=> (victim == '0 && valid_vec == '0));

  assert_lookup_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (lk_hit != lk_miss));

  assert_no_idle_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && !lk_miss));

  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0 && lk_attr == '0 && !lk_hit));
endmodule

bind devmmu_tlb devmmu_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES), .ATTR_W(ATTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .victim(victim), .armed(armed), .ev_load(ev_load), .ev_flush_slot(ev_flush_slot),
  .ev_flush_all(ev_flush_all), .valid_vec(valid_vec), .lk_valid(lk_valid),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_attr(lk_attr)
);

// File: tb/devmmu_tlb_tb_top.sv
`timescale 1ns/1ps
module devmmu_tlb_tb_top;
  localparam int N = 6;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [31:0] cmd_arg = '0;
  logic stage_wr = 1'b0;
  logic [31:0] stage_va = '0, stage_pa = '0;
  logic [1:0] stage_size = '0;
  logic [AW-1:0] stage_attr = '0;
  logic [2:0] victim;
  logic rd_valid;
  logic [31:0] rd_va, rd_pa;
  logic [1:0] rd_size;
  logic [AW-1:0] rd_attr;
  logic lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic [AW-1:0] lk_attr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  devmmu_tlb #(.NUM_ENTRIES(N), .ATTR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .stage_wr(stage_wr), .stage_va(stage_va), .stage_size(stage_size),
    .stage_pa(stage_pa), .stage_attr(stage_attr), .victim(victim),
    .rd_valid(rd_valid), .rd_va(rd_va), .rd_size(rd_size), .rd_pa(rd_pa), .rd_attr(rd_attr),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_pa(lk_pa), .lk_attr(lk_attr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0;
  endtask

  task automatic stage(input logic [31:0] va, input logic [1:0] sz,
                       input logic [31:0] pa, input logic [AW-1:0] at);
    @(negedge clk);
    stage_wr = 1'b1; stage_va = va; stage_size = sz; stage_pa = pa; stage_attr = at;
    @(negedge clk);
    stage_wr = 1'b0;
  endtask

  task automatic load_at(input int slot, input logic [31:0] va, input logic [1:0] sz,
                         input logic [31:0] pa, input logic [AW-1:0] at);
    stage(va, sz, pa, at);
    send(3'd1, 32'(slot));
    send(3'd2, 32'h0);
    send(3'd3, 32'h0);
  endtask

  // Checks one lookup: result one cycle later, strobes gone the cycle after.
  task automatic look(input string tag, input logic [31:0] a, input bit exp_hit,
                      input logic [31:0] exp_pa, input logic [AW-1:0] exp_attr);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " hit"}, 64'(lk_hit), 64'(exp_hit));
    chk({tag, " miss"}, 64'(lk_miss), 64'(!exp_hit));
    chk({tag, " pa"}, 64'(lk_pa), 64'(exp_pa));
    chk({tag, " attr"}, 64'(lk_attr), 64'(exp_attr));
    @(negedge clk);
    chk({tag, " strobe one cycle R11"}, 64'({lk_hit, lk_miss}), 64'(0));
  endtask

  task automatic rb_valid(input string tag, input int slot, input bit exp_v);
    send(3'd1, 32'(slot));
    chk(tag, 64'(rd_valid), 64'(exp_v));
  endtask

  task automatic t_reset;
    chk("R1 victim", 64'(victim), 64'(0));
    chk("R1 hit/miss", 64'({lk_hit, lk_miss}), 64'(0));
    chk("R1 pa", 64'(lk_pa), 64'(0));
    for (int s = 0; s < N; s++) rb_valid("R1 slot invalid", s, 1'b0);
  endtask

  task automatic t_basic_load;
    load_at(0, 32'h1234_5678, 2'd3, 32'h8000_0000, 4'h5);
    chk("R4 victim after load", 64'(victim), 64'(1));
    send(3'd1, 32'h0);
    chk("R3 rd_valid", 64'(rd_valid), 64'(1));
    chk("R2 rd_va aligned", 64'(rd_va), 64'h1234_5000);
    chk("R5 rd_size", 64'(rd_size), 64'(3));
    chk("R5 rd_pa", 64'(rd_pa), 64'h8000_0000);
    chk("R5 rd_attr", 64'(rd_attr), 64'(5));
    look("R9 4K hit", 32'h1234_5ABC, 1'b1, 32'h8000_0ABC, 4'h5);
    look("R11 4K next page", 32'h1234_6000, 1'b0, 32'h0, 4'h0);
  endtask

  task automatic t_unarmed;
    send(3'd1, 32'd2);
    stage(32'h0900_0000, 2'd1, 32'h0A00_0000, 4'h9);
    send(3'd3, 32'h0);
    chk("R3 load without flush victim", 64'(victim), 64'(2));
    chk("R3 load without flush slot", 64'(rd_valid), 64'(0));
    send(3'd2, 32'h0);
    send(3'd0, 32'h0);
    send(3'd3, 32'h0);
    chk("R3 interrupted pair victim", 64'(victim), 64'(2));
    chk("R3 interrupted pair slot", 64'(rd_valid), 64'(0));
  endtask

  task automatic t_sizes;
    load_at(1, 32'h05AB_CDEF, 2'd0, 32'hA000_0000, 4'h1);
    send(3'd1, 32'd1);
    chk("R2 16M base aligned", 64'(rd_va), 64'h0500_0000);
    look("R2 16M last byte", 32'h05FF_FFFF, 1'b1, 32'hA0FF_FFFF, 4'h1);
    look("R2 16M past end", 32'h0600_0000, 1'b0, 32'h0, 4'h0);
    load_at(2, 32'h2000_0000, 2'd1, 32'h3000_0000, 4'h2);
    look("R2 1M last byte", 32'h200F_FFFF, 1'b1, 32'h300F_FFFF, 4'h2);
    look("R2 1M past end", 32'h2010_0000, 1'b0, 32'h0, 4'h0);
    load_at(3, 32'h4001_0000, 2'd2, 32'h5000_0000, 4'h3);
    look("R2 64K last byte", 32'h4001_FFFF, 1'b1, 32'h5000_FFFF, 4'h3);
    look("R2 64K past end", 32'h4002_0000, 1'b0, 32'h0, 4'h0);
    look("R2 64K before start", 32'h4000_FFFF, 1'b0, 32'h0, 4'h0);
  endtask

  task automatic t_priority_wrap;
    load_at(4, 32'h7000_0000, 2'd1, 32'h1110_0000, 4'h6);
    load_at(5, 32'h7000_0000, 2'd3, 32'h2220_0000, 4'h7);
    chk("R4 wrap to 0", 64'(victim), 64'(0));
    look("R10 lowest slot wins", 32'h7000_0123, 1'b1, 32'h1110_0123, 4'h6);
  endtask

  task automatic t_flush_addr;
    send(3'd1, 32'd3);
    send(3'd4, 32'h7000_0500);
    chk("R7 victim unchanged", 64'(victim), 64'(3));
    rb_valid("R7 slot4 flushed", 4, 1'b0);
    rb_valid("R7 slot5 flushed", 5, 1'b0);
    rb_valid("R7 slot0 kept", 0, 1'b1);
    rb_valid("R7 slot3 kept", 3, 1'b1);
    look("R7 other entry still hits", 32'h1234_5ABC, 1'b1, 32'h8000_0ABC, 4'h5);
  endtask

  task automatic t_set_victim;
    send(3'd1, 32'd4);
    send(3'd1, 32'd7);
    chk("R5 out-of-range 7 ignored", 64'(victim), 64'(4));
    send(3'd1, 32'd6);
    chk("R5 out-of-range 6 ignored", 64'(victim), 64'(4));
  endtask

  task automatic t_flush_slot;
    send(3'd1, 32'd0);
    send(3'd2, 32'h0);
    chk("R6 slot0 invalid", 64'(rd_valid), 64'(0));
    chk("R6 victim unchanged", 64'(victim), 64'(0));
    rb_valid("R6 slot1 kept", 1, 1'b1);
    look("R6 flushed entry misses", 32'h1234_5ABC, 1'b0, 32'h0, 4'h0);
  endtask

  task automatic t_flush_all;
    send(3'd1, 32'd3);
    send(3'd5, 32'h0);
    chk("R8 victim zero", 64'(victim), 64'(0));
    for (int s = 0; s < N; s++) rb_valid("R8 slot invalid", s, 1'b0);
    look("R8 lookup misses", 32'h4001_FFFF, 1'b0, 32'h0, 4'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_load();
    t_unarmed();
    t_sizes();
    t_priority_wrap();
    t_flush_addr();
    t_set_victim();
    t_flush_slot();
    t_flush_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule